// File: doc/BRIEF.md
# Serial ADC host sequencer

This block is the host side of a 16-bit serial link to an external analog-to-digital converter. It generates the serial clock, the chip-select and frame-sync strobes and the host data line, and it collects the word the converter shifts back on its data output. The serial clock is derived from the system clock by a fixed divider. Host data changes on the falling serial clock edge. Returned data is sampled on the rising edge, most significant bit first.

After reset the block brings the converter up along one of two paths, selected by a parameter. The default-mode path sends two back-to-back frames with the host data line held high. The programmed path first sends the unlock word A000h, then a configuration write made of a 4-bit command and a 12-bit value. While this runs, the block reports busy and ignores requests.

Once it is ready, each start request sends a command frame whose 4-bit command sits in bits [15:12], with zeros below. The block then extracts the left-justified result from the returned word and presents it right-justified as a one-cycle valid pulse with data. The first result after power-up is never presented.

Top module: `adc_link_seq`

## Requirements
- R1: While reset is held, `busy_o` is 1, `cs_n_o` is 1, `sclk_o` is 0, `fs_o` is 0 and `res_valid_o` is 0. Any `start_i` seen while `busy_o` is 1 launches no frame.
- R2: With `SW_INIT`=1, the first frame after reset carries A000h and the second carries {`CFG_CMD`, `CFG_WORD`} (command in bits [15:12], value in bits [11:0]). After the second frame and its idle gap, `busy_o` falls.
- R3: With `SW_INIT`=0, the two frames after reset carry FFFFh, so the host data line is high at every rising serial clock edge, and each frame has 16 serial clock cycles.
- R4: Every frame holds `cs_n_o` low across exactly 16 rising edges of `sclk_o`. `sclk_o` is high only while `cs_n_o` is low. `fs_o` is high in the cycle in which `cs_n_o` falls and is high only while `cs_n_o` is low.
- R5: Words go out and come in most significant bit first. `sdi_o` changes during a frame only when `sclk_o` falls or when `cs_n_o` falls, and `sdo_i` is taken at each rising edge of `sclk_o`.
- R6: Between two frames, `cs_n_o` stays high for at least 2 serial clock periods (4 × `HALF_DIV` system clocks).
- R7: When `busy_o` is 0, a `start_i` launches the frame {`cmd_i`, 12'h000`}: `cs_n_o` is low and `busy_o` is 1 in the next cycle, and `busy_o` stays 1 until the frame's idle gap ends. While `busy_o` is 0, `cs_n_o` is 1.
- R8: The word returned by the first command frame after reset produces no result. Every later command frame produces exactly one single-cycle `res_valid_o` pulse. Initialization frames produce none.
- R9: `res_data_o` holds returned bits [15:16-`RES_BITS`], right-justified: bits [15:2] when `RES_BITS`=14, bits [15:4] when `RES_BITS`=12.
- R10: A `start_i` held high through initialization is accepted in the first cycle in which `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one command frame |
| cmd_i | input | 4 | Command nibble for the requested frame |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| sdi_o | output | 1 | Host-to-converter serial data |
| cs_n_o | output | 1 | Active-low chip select, low for one frame |
| fs_o | output | 1 | Frame-sync strobe, rises when a frame starts |
| sdo_i | input | 1 | Converter-to-host serial data |
| busy_o | output | 1 | High while initializing or while a frame or its gap is in progress |
| res_valid_o | output | 1 | Single-cycle result strobe |
| res_data_o | output | RES_BITS | Right-justified conversion result |

## Verification
The critical coincidence is a start request arriving in the very cycle in which initialization ends and `busy_o` falls. The bench provokes it by holding `start_i` high from reset, through both initialization frames, and into the first ready cycle. It then judges that exactly two frames went out before the command frame, that `busy_o` and `cs_n_o` change in the cycle straight after the first ready cycle, and that the command frame carries the requested nibble. A second coincidence is a result strobe landing while the next request waits. The scoreboard checks that every strobe matches the queued value for its own frame, so a result that is shifted by one frame or dropped is reported.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned WORD_W = 16;
   localparam int unsigned CMD_W  = 4;
   localparam int unsigned CFG_W  = WORD_W - CMD_W;

   localparam logic [WORD_W-1:0] UNLOCK_WORD = 16'hA000;

   typedef enum logic [1:0] {
      SQ_INIT_GO,
      SQ_INIT_WAIT,
      SQ_READY,
      SQ_CMD_WAIT
   } seq_state_t;

   typedef enum logic [1:0] {
      FE_IDLE,
      FE_SHIFT,
      FE_GAP
   } fe_state_t;

   // Word sent in initialization frame 'second' (0 or 1).
   function automatic logic [WORD_W-1:0] init_word(
      input logic             sw_mode,
      input logic             second,
      input logic [CMD_W-1:0] cfg_cmd,
      input logic [CFG_W-1:0] cfg_val);
      if (!sw_mode)
         return '1;
      else if (!second)
         return UNLOCK_WORD;
      else
         return {cfg_cmd, cfg_val};
   endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   if (HALF_DIV < 1) begin : g_bad_div
      $error("adc_sclk_div: HALF_DIV must be at least 1");
   end

   generate
      if (HALF_DIV == 1) begin : g_pass
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

endmodule

// File: rtl/adc_frame_eng.sv
module adc_frame_eng
   import adc_seq_pkg::*;
#(
   parameter int unsigned HALF_DIV   = 2,
   parameter int unsigned FRAME_BITS = 16,
   parameter int unsigned GAP_SCLK   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [FRAME_BITS-1:0] tx_word,
   input  logic                  sdo_i,
   output logic                  sclk_o,
   output logic                  sdi_o,
   output logic                  cs_n_o,
   output logic                  fs_o,
   output logic                  idle_o,
   output logic                  done_o,
   output logic [FRAME_BITS-1:0] rx_word
);

   localparam int unsigned HALVES     = 2 * FRAME_BITS;
   localparam int unsigned GAP_HALVES = 2 * GAP_SCLK;
   localparam int unsigned PH_MAX     = (HALVES > GAP_HALVES) ? HALVES : GAP_HALVES;
   localparam int unsigned PH_W       = $clog2(PH_MAX + 1);
   localparam int unsigned GAP_CYC    = GAP_HALVES * HALF_DIV;
   localparam int unsigned GC_W       = $clog2(GAP_CYC + 2);
   localparam int unsigned RC_W       = $clog2(FRAME_BITS + 2);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("adc_frame_eng: FRAME_BITS must be at least 2");
   end
   if (GAP_SCLK < 1) begin : g_bad_gap
      $error("adc_frame_eng: GAP_SCLK must be at least 1");
   end

   fe_state_t             state;
   logic [PH_W-1:0]       ph;
   logic [FRAME_BITS-1:0] shreg;
   logic [FRAME_BITS-1:0] rx;
   logic                  sclk_q;
   logic                  cs_n_q;
   logic                  fs_q;
   logic                  done_q;
   logic                  tick;

   adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state != FE_IDLE),
      .tick (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= FE_IDLE;
         ph     <= '0;
         shreg  <= '0;
         rx     <= '0;
         sclk_q <= 1'b0;
         cs_n_q <= 1'b1;
         fs_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            FE_IDLE: begin
               if (go) begin
                  state  <= FE_SHIFT;
                  cs_n_q <= 1'b0;
                  fs_q   <= 1'b1;
                  shreg  <= tx_word;
                  ph     <= '0;
               end
            end
            FE_SHIFT: begin
               if (tick) begin
                  ph <= ph + 1'b1;
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                     fs_q   <= 1'b0;
                     rx     <= {rx[FRAME_BITS-2:0], sdo_i};
                  end else begin
                     sclk_q <= 1'b0;
                     if (ph == PH_W'(HALVES - 1)) begin
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        state  <= FE_GAP;
                        ph     <= '0;
                     end else begin
                        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                     end
                  end
               end
            end
            FE_GAP: begin
               if (tick) begin
                  if (ph == PH_W'(GAP_HALVES - 1)) begin
                     state <= FE_IDLE;
                     ph    <= '0;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
            end
            default: state <= FE_IDLE;
         endcase
      end
   end

   assign sclk_o  = sclk_q;
   assign sdi_o   = shreg[FRAME_BITS-1];
   assign cs_n_o  = cs_n_q;
   assign fs_o    = fs_q;
   assign idle_o  = (state == FE_IDLE);
   assign done_o  = done_q;
   assign rx_word = rx;

   // ---------------- checks ----------------
   logic            sclk_d;
   logic [RC_W-1:0] rise_cnt;
   logic [GC_W-1:0] high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         rise_cnt <= '0;
         high_cnt <= GC_W'(GAP_CYC);
      end else begin
         sclk_d <= sclk_o;
         if (cs_n_o)
            rise_cnt <= '0;
         else if (sclk_o && !sclk_d)
            rise_cnt <= rise_cnt + 1'b1;
         if (!cs_n_o)
            high_cnt <= '0;
         else if (high_cnt < GC_W'(GAP_CYC))
            high_cnt <= high_cnt + 1'b1;
      end
   end

   p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !cs_n_o);

   p_fs_at_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> fs_o);

   p_fs_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fs_o |-> !cs_n_o);

   p_sixteen_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (rise_cnt == RC_W'(FRAME_BITS)));

   p_sdi_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && !$stable(sdi_o)) |-> ($fell(sclk_o) || $fell(cs_n_o)));

   p_idle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (high_cnt >= GC_W'(GAP_CYC)));

endmodule

// File: rtl/adc_result_pick.sv
module adc_result_pick #(
   parameter int unsigned RES_BITS   = 14,
   parameter int unsigned FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap,
   input  logic [FRAME_BITS-1:0] raw,
   output logic                  res_valid_o,
   output logic [RES_BITS-1:0]   res_data_o
);

   localparam int unsigned TAIL = FRAME_BITS - RES_BITS;

   if (RES_BITS != 12 && RES_BITS != 14) begin : g_bad_res
      $error("adc_result_pick: RES_BITS must be 12 or 14");
   end

   logic [RES_BITS-1:0] picked;
   logic                unused_tail_bits;

   generate
      if (RES_BITS == 14) begin : g_res14
         assign picked           = raw[FRAME_BITS-1 -: 14];
         assign unused_tail_bits = ^raw[TAIL-1:0];
      end else begin : g_res12
         assign picked           = raw[FRAME_BITS-1 -: 12];
         assign unused_tail_bits = ^raw[TAIL-1:0];
      end
   endgenerate

   logic primed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed      <= 1'b0;
         res_valid_o <= 1'b0;
         res_data_o  <= '0;
      end else begin
         res_valid_o <= 1'b0;
         if (cap) begin
            if (primed) begin
               res_valid_o <= 1'b1;
               res_data_o  <= picked;
            end
            primed <= 1'b1;
         end
      end
   end

   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |=> !res_valid_o);

endmodule

// File: rtl/adc_link_seq.sv
module adc_link_seq
   import adc_seq_pkg::*;
#(
   parameter int unsigned   HALF_DIV = 2,
   parameter int unsigned   RES_BITS = 14,
   parameter int unsigned   GAP_SCLK = 2,
   parameter bit            SW_INIT  = 1'b1,
   parameter logic [3:0]    CFG_CMD  = 4'hA,
   parameter logic [11:0]   CFG_WORD = 12'h5A3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [3:0]          cmd_i,
   output logic                sclk_o,
   output logic                sdi_o,
   output logic                cs_n_o,
   output logic                fs_o,
   input  logic                sdo_i,
   output logic                busy_o,
   output logic                res_valid_o,
   output logic [RES_BITS-1:0] res_data_o
);

   if (RES_BITS != 12 && RES_BITS != 14) begin : g_bad_res
      $error("adc_link_seq: RES_BITS must be 12 or 14");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("adc_link_seq: HALF_DIV must be at least 1");
   end

   seq_state_t          sq;
   logic                init_second;
   logic                eng_go;
   logic [WORD_W-1:0]   eng_tx;
   logic                eng_idle;
   logic                eng_done;
   logic [WORD_W-1:0]   eng_rx;
   logic                cap;

   always_comb begin
      eng_go = 1'b0;
      eng_tx = {cmd_i, {CFG_W{1'b0}}};
      case (sq)
         SQ_INIT_GO: begin
            eng_go = 1'b1;
            eng_tx = init_word(SW_INIT, init_second, CFG_CMD, CFG_WORD);
         end
         SQ_READY: eng_go = start_i;
         default: eng_go = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq          <= SQ_INIT_GO;
         init_second <= 1'b0;
      end else begin
         case (sq)
            SQ_INIT_GO:   sq <= SQ_INIT_WAIT;
            SQ_INIT_WAIT: begin
               if (eng_idle) begin
                  if (init_second) begin
                     sq <= SQ_READY;
                  end else begin
                     init_second <= 1'b1;
                     sq          <= SQ_INIT_GO;
                  end
               end
            end
            SQ_READY:     if (start_i) sq <= SQ_CMD_WAIT;
            SQ_CMD_WAIT:  if (eng_idle) sq <= SQ_READY;
            default:      sq <= SQ_INIT_GO;
         endcase
      end
   end

   assign busy_o = (sq != SQ_READY);
   assign cap    = eng_done && (sq == SQ_CMD_WAIT);

   adc_frame_eng #(
      .HALF_DIV  (HALF_DIV),
      .FRAME_BITS(WORD_W),
      .GAP_SCLK  (GAP_SCLK)
   ) u_eng (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (eng_go),
      .tx_word(eng_tx),
      .sdo_i  (sdo_i),
      .sclk_o (sclk_o),
      .sdi_o  (sdi_o),
      .cs_n_o (cs_n_o),
      .fs_o   (fs_o),
      .idle_o (eng_idle),
      .done_o (eng_done),
      .rx_word(eng_rx)
   );

   adc_result_pick #(
      .RES_BITS  (RES_BITS),
      .FRAME_BITS(WORD_W)
   ) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (cap),
      .raw        (eng_rx),
      .res_valid_o(res_valid_o),
      .res_data_o (res_data_o)
   );

   // ---------------- checks ----------------
   logic [1:0] cmd_frames;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cmd_frames <= '0;
      else if (cap && cmd_frames != 2'd2)
         cmd_frames <= cmd_frames + 1'b1;
   end

   p_busy_ignores_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && eng_idle && sq != SQ_INIT_GO) |=> cs_n_o);

   p_ready_no_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> cs_n_o);

   p_accept_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !cs_n_o));

   p_first_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (cmd_frames == 2'd2));

endmodule

// File: tb/test_adc_link_seq.sv
module test_adc_slave (
   input  logic sclk,
   input  logic cs_n,
   input  logic fs,
   input  logic sdi,
   output logic sdo
);
   logic [15:0] resp      [0:15];
   logic [15:0] host_word [0:15];
   int          bit_cnt   [0:15];
   int          nframes   = 0;
   int          fs_starts = 0;
   int          bitpos    = 0;
   int          bits      = 0;
   logic [15:0] rxs       = '0;
   realtime     t_rise    = 0;
   realtime     min_gap   = 1.0e9;

   initial begin
      sdo = 1'b0;
      for (int k = 0; k < 16; k++) begin
         resp[k]      = 16'h3C5A ^ 16'(k * 16'h1D2B);
         host_word[k] = '0;
         bit_cnt[k]   = 0;
      end
   end

   always @(negedge cs_n) begin
      if (nframes > 0 && ($realtime - t_rise) < min_gap)
         min_gap = $realtime - t_rise;
      if (fs) fs_starts++;
      bitpos = 15;
      bits   = 0;
      rxs    = '0;
      sdo    = resp[nframes % 16][15];
   end

   always @(negedge sclk) begin
      if (!cs_n && bitpos > 0) begin
         bitpos--;
         sdo = resp[nframes % 16][bitpos];
      end
   end

   always @(posedge sclk) begin
      if (!cs_n) begin
         rxs = {rxs[14:0], sdi};
         bits++;
      end
   end

   always @(posedge cs_n) begin
      if (bits > 0) begin
         if (nframes < 16) begin
            host_word[nframes] = rxs;
            bit_cnt[nframes]   = bits;
         end
         nframes++;
         bits   = 0;
         t_rise = $realtime;
      end
   end
endmodule

module test_adc_link_seq;
   localparam int HALF_A = 2;
   localparam int HALF_B = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        start_a = 1'b0, start_b = 1'b0;
   logic [3:0]  cmd_a = '0, cmd_b = '0;
   logic        sclk_a, sdi_a, cs_a, fs_a, sdo_a, busy_a, vld_a;
   logic        sclk_b, sdi_b, cs_b, fs_b, sdo_b, busy_b, vld_b;
   logic [13:0] dat_a;
   logic [11:0] dat_b;

   adc_link_seq #(.HALF_DIV(HALF_A), .RES_BITS(14), .SW_INIT(1'b1),
                  .CFG_CMD(4'hA), .CFG_WORD(12'h5A3)) i_adc_link_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_a), .cmd_i(cmd_a),
      .sclk_o(sclk_a), .sdi_o(sdi_a), .cs_n_o(cs_a), .fs_o(fs_a), .sdo_i(sdo_a),
      .busy_o(busy_a), .res_valid_o(vld_a), .res_data_o(dat_a));

   adc_link_seq #(.HALF_DIV(HALF_B), .RES_BITS(12), .SW_INIT(1'b0)) i_adc_link_seq_hw (
      .clk(clk), .rst_n(rst_n), .start_i(start_b), .cmd_i(cmd_b),
      .sclk_o(sclk_b), .sdi_o(sdi_b), .cs_n_o(cs_b), .fs_o(fs_b), .sdo_i(sdo_b),
      .busy_o(busy_b), .res_valid_o(vld_b), .res_data_o(dat_b));

   test_adc_slave u_slv_a (.sclk(sclk_a), .cs_n(cs_a), .fs(fs_a), .sdi(sdi_a), .sdo(sdo_a));
   test_adc_slave u_slv_b (.sclk(sclk_b), .cs_n(cs_b), .fs(fs_b), .sdi(sdi_b), .sdo(sdo_b));

   int n_chk = 0;
   int n_fail = 0;
   int got_a = 0, got_b = 0;
   int cmds_a = 0, cmds_b = 0;
   logic [13:0] q_a[$];
   logic [11:0] q_b[$];
   logic [3:0]  sent_a[$];
   logic [3:0]  sent_b[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitors
   always @(negedge clk) begin
      if (rst_n && vld_a) begin
         got_a++;
         if (q_a.size() == 0)
            check(1'b0, "R8", "unexpected result on 14-bit link", dat_a, 0);
         else begin
            check(dat_a == q_a[0], "R9", "14-bit result", dat_a, q_a[0]);
            void'(q_a.pop_front());
         end
      end
      if (rst_n && vld_b) begin
         got_b++;
         if (q_b.size() == 0)
            check(1'b0, "R8", "unexpected result on 12-bit link", dat_b, 0);
         else begin
            check(dat_b == q_b[0], "R9", "12-bit result", dat_b, q_b[0]);
            void'(q_b.pop_front());
         end
      end
   end

   // Drivers: issue a command when idle, push the expected result
   task automatic issue_a(input logic [3:0] c);
      int idx;
      do @(negedge clk); while (busy_a);
      idx     = u_slv_a.nframes;
      start_a = 1'b1;
      cmd_a   = c;
      @(negedge clk);
      start_a = 1'b0;
      check(busy_a && !cs_a, "R7", "launch on 14-bit link", {busy_a, cs_a}, 2'b10);
      if (cmds_a > 0) q_a.push_back(u_slv_a.resp[idx][15:2]);
      sent_a.push_back(c);
      cmds_a++;
   endtask

   task automatic issue_b(input logic [3:0] c);
      int idx;
      do @(negedge clk); while (busy_b);
      idx     = u_slv_b.nframes;
      start_b = 1'b1;
      cmd_b   = c;
      @(negedge clk);
      start_b = 1'b0;
      check(busy_b && !cs_b, "R7", "launch on 12-bit link", {busy_b, cs_b}, 2'b10);
      if (cmds_b > 0) q_b.push_back(u_slv_b.resp[idx][15:4]);
      sent_b.push_back(c);
      cmds_b++;
   endtask

   task automatic run_all();
      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy_a == 1'b1, "R1", "busy in reset", busy_a, 1);
      check(cs_a == 1'b1 && sclk_a == 1'b0 && fs_a == 1'b0, "R1", "link idle in reset",
            {cs_a, sclk_a, fs_a}, 3'b100);
      check(vld_a == 1'b0 && vld_b == 1'b0, "R1", "no result in reset", {vld_a, vld_b}, 0);

      // R10: hold start through initialization of the 14-bit link
      start_a = 1'b1;
      cmd_a   = 4'h1;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      start_b = 1'b1;      // R1: request during init on the default-mode link
      cmd_b   = 4'h7;
      @(negedge clk);
      start_b = 1'b0;

      do @(negedge clk); while (busy_a);
      check(u_slv_a.nframes == 2, "R1", "frames before ready with start held",
            u_slv_a.nframes, 2);
      @(negedge clk);
      start_a = 1'b0;
      check(busy_a && !cs_a, "R10", "start accepted in first ready cycle",
            {busy_a, cs_a}, 2'b10);
      sent_a.push_back(4'h1);
      cmds_a = 1;

      check(u_slv_a.host_word[0] == 16'hA000, "R2", "unlock word", u_slv_a.host_word[0], 16'hA000);
      check(u_slv_a.host_word[1] == 16'hA5A3, "R2", "config word", u_slv_a.host_word[1], 16'hA5A3);
      check(u_slv_a.bit_cnt[0] == 16 && u_slv_a.bit_cnt[1] == 16, "R4", "init frame length",
            u_slv_a.bit_cnt[1], 16);

      issue_a(4'h2);
      issue_a(4'hC);
      issue_a(4'h0);
      issue_a(4'hF);
      do @(negedge clk); while (busy_a);
      repeat (4) @(negedge clk);

      for (int k = 0; k < 5; k++) begin
         check(u_slv_a.host_word[2+k] == {sent_a[k], 12'h000}, "R5", "command word MSB first",
               u_slv_a.host_word[2+k], {sent_a[k], 12'h000});
         check(u_slv_a.bit_cnt[2+k] == 16, "R4", "command frame length",
               u_slv_a.bit_cnt[2+k], 16);
      end
      check(got_a == 4, "R8", "results on 14-bit link (first dropped)", got_a, 4);
      check(q_a.size() == 0, "R8", "pending results on 14-bit link", q_a.size(), 0);
      check(u_slv_a.fs_starts == u_slv_a.nframes, "R4", "frame sync at each start",
            u_slv_a.fs_starts, u_slv_a.nframes);
      check(u_slv_a.min_gap >= 4.0 * HALF_A * 10.0, "R6", "idle gap 14-bit link (ns)",
            longint'(u_slv_a.min_gap), 4 * HALF_A * 10);

      // Default-mode link
      do @(negedge clk); while (busy_b);
      check(u_slv_b.nframes == 2, "R1", "request during init ignored", u_slv_b.nframes, 2);
      check(u_slv_b.host_word[0] == 16'hFFFF && u_slv_b.host_word[1] == 16'hFFFF, "R3",
            "default-mode frames high", u_slv_b.host_word[1], 16'hFFFF);
      check(u_slv_b.bit_cnt[0] == 16 && u_slv_b.bit_cnt[1] == 16, "R3",
            "default-mode frame length", u_slv_b.bit_cnt[0], 16);
      issue_b(4'h3);
      issue_b(4'h9);
      issue_b(4'h6);
      do @(negedge clk); while (busy_b);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 3; k++)
         check(u_slv_b.host_word[2+k] == {sent_b[k], 12'h000}, "R7", "12-bit link command word",
               u_slv_b.host_word[2+k], {sent_b[k], 12'h000});
      check(got_b == 2, "R8", "results on 12-bit link (first dropped)", got_b, 2);
      check(u_slv_b.min_gap >= 4.0 * HALF_B * 10.0, "R6", "idle gap 12-bit link (ns)",
            longint'(u_slv_b.min_gap), 4 * HALF_B * 10);
   endtask

   initial begin
      bit timed_out;
      timed_out = 1'b0;
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung run, expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule